// File: doc/BRIEF.md
# Synchronous Byte Shifter for I/O Expansion

This block is the shift-register mode of a serial port, used to hang external shift registers off a controller. It moves one byte at a time in either direction, never both at once. The shift clock is made inside the block from the oscillator clock. Each bit lasts one machine cycle of 12 oscillator clocks, and bits go least significant first.

A free-running machine-cycle counter starts at zero when reset is released. Every transfer starts at the next machine-cycle boundary after its request, so the data and the shift clock edges always sit at fixed phases of that cycle. The serial output changes at phase 0 of a bit. The shift clock falls at phase 4 and rises at phase 10, so the data is set up 10 clocks before the rising edge and held for 2 clocks after it. On a receive, the serial input is taken on the rising edge. The received byte and the two completion flags stay in place until later activity changes them.

Top module: `sync_shift_port`

## Requirements
- R1: While reset is held at a clock edge, the block returns to its idle state: `sck` = 1, `sdo` = 1, `rx_byte` = 0, `tx_done` = 0 and `rx_done` = 0.
- R2: The first oscillator edge after a released reset is counted as edge 1. A request is captured at edge N. The first bit then starts at edge M, the smallest multiple of 12 greater than N. Bit b occupies edges M+12b to M+12b+11.
- R3: On a transmit, bit b of the loaded byte drives `sdo` for the whole of bit slot b. Bit 0 goes first.
- R4: `sck` is 1 outside transfers. Within a bit slot, phase q = (edge − M) mod 12, and `sck` is 0 exactly for 4 ≤ q ≤ 9. Its rising edge therefore comes 10 clocks after the data change, and the data holds for the 2 clocks that follow.
- R5: On a receive, the value of `sdi` in the clock before the rising edge of bit slot b lands in `rx_byte[b]`. The value of `sdi` at other phases has no effect.
- R6: `rx_byte` changes only at edge M+96 of a receive, and holds its value at every other time.
- R7: `tx_done` goes to 1 at edge M+96 of a transmit, and `rx_done` does the same for a receive. Both flags clear when the next request is accepted, so they are 0 from N until M+95.
- R8: `tx_load` and `rx_start` are ignored while a request is pending or a byte is in flight. The current byte is not altered, and no further transfer follows it.
- R9: If `tx_load` and `rx_start` arrive in the same cycle, a transmit is performed. `rx_byte` is left unchanged.
- R10: `sdo` stays 1 whenever no transmit is in progress, including throughout a receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_load | input | 1 | Request to transmit `tx_byte` |
| tx_byte | input | DATA_W | Byte to send, taken with the request |
| rx_start | input | 1 | Request to receive one byte |
| sdi | input | 1 | Serial data input |
| sck | output | 1 | Shift clock, idles high |
| sdo | output | 1 | Serial data output, idles high |
| rx_byte | output | DATA_W | Last byte received |
| tx_done | output | 1 | Transmit completed |
| rx_done | output | 1 | Receive completed |

## Verification
Single-bit bytes 0x01 and 0x80 distinguish LSB-first from MSB-first order in both directions. 0xA5, 0x00 and 0xFF expose stuck or swapped bits. The idle gap before each request is varied so the request lands at many phases of the machine cycle, including the one just before a boundary; this separates correct start alignment from off-by-one-cycle starts. During receives, `sdi` carries the true bit only in the single clock before the rising edge and the inverted bit at all other phases, so any other sampling instant corrupts the byte. Further tests cover requests made mid-byte, simultaneous requests, and a reset in the middle of a transfer.

// File: rtl/ssp_pkg.sv
// Shared types for the synchronous byte shifter.
// Assumes: included first in compile order.
package ssp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // nothing in flight, requests accepted
        ST_WAIT = 2'd1,   // request taken, waiting for machine-cycle boundary
        ST_RUN  = 2'd2    // bits being shifted
    } ssp_state_t;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } ssp_dir_t;
endpackage

// File: rtl/ssp_cycle_timer.sv
// Free-running machine-cycle phase counter.
// Counts 0..CYC_LEN-1 and wraps; cleared by reset so phase 0 lines up with
// the release of reset. Assumes CYC_LEN >= 2.
module ssp_cycle_timer #(
    parameter int CYC_LEN = 12,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph_o,
    output logic            ph_last_o
);
    assign ph_last_o = (ph_o == PH_W'(CYC_LEN - 1));

    // Advance the phase, wrapping at the end of the machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_o <= '0;
        else if (ph_last_o)
            ph_o <= '0;
        else
            ph_o <= ph_o + 1'b1;
    end

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ph_last_o |=> (ph_o == '0));  // R2
endmodule

// File: rtl/ssp_seq_ctrl.sv
// Transfer sequencer: accepts a request only when idle, waits for the next
// machine-cycle boundary, then counts NBITS bit slots. Makes the shift clock
// from the phase and issues the strobes the datapath needs.
// Assumes 0 < SCK_FALL < SCK_RISE < CYC_LEN.
module ssp_seq_ctrl
    import ssp_pkg::*;
#(
    parameter int CYC_LEN  = 12,
    parameter int NBITS    = 8,
    parameter int SCK_FALL = 4,
    parameter int SCK_RISE = 10,
    localparam int PH_W = $clog2(CYC_LEN),
    localparam int BC_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] ph_i,
    input  logic            ph_last_i,
    input  logic            tx_load_i,
    input  logic            rx_start_i,
    output logic            accept_o,
    output ssp_dir_t        dir_o,
    output logic            run_o,
    output logic            bit_end_o,
    output logic            sample_en_o,
    output logic            xfer_end_o,
    output logic            sck_o
);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(NBITS - 1);

    ssp_state_t      state_q;
    logic [BC_W-1:0] bitcnt_q;

    // Requests are taken only from idle; transmit wins a tie.
    assign accept_o    = (state_q == ST_IDLE) && (tx_load_i || rx_start_i);
    assign run_o       = (state_q == ST_RUN);
    assign bit_end_o   = run_o && ph_last_i;
    assign xfer_end_o  = bit_end_o && (bitcnt_q == LAST_BIT);
    assign sample_en_o = run_o && (ph_i == PH_W'(SCK_RISE - 1));
    assign sck_o       = !(run_o && (ph_i >= PH_W'(SCK_FALL)) && (ph_i < PH_W'(SCK_RISE)));

    // State, direction and bit-slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            dir_o    <= DIR_TX;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        state_q <= ST_WAIT;
                        dir_o   <= tx_load_i ? DIR_TX : DIR_RX;
                    end
                end
                ST_WAIT: begin
                    if (ph_last_i) begin
                        state_q  <= ST_RUN;
                        bitcnt_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (ph_last_i) begin
                        if (bitcnt_q == LAST_BIT)
                            state_q <= ST_IDLE;
                        else
                            bitcnt_q <= bitcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_RUN_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> (ph_i == '0));  // R2
    AST_SCK_RISE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sck_o) && run_o) |-> (ph_i == PH_W'(SCK_RISE)));  // R4
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && (tx_load_i || rx_start_i)) |=> $stable(dir_o));  // R8
endmodule

// File: rtl/ssp_shift_dp.sv
// Shift datapath: transmit register shifted right once per bit slot,
// receive register filled from the top at each sample strobe, the received
// byte register, and the two completion flags.
// Assumes strobes come from ssp_seq_ctrl and dir_i is steady during a transfer.
module ssp_shift_dp
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  ssp_dir_t          dir_i,
    input  logic              run_i,
    input  logic              bit_end_i,
    input  logic              sample_en_i,
    input  logic              xfer_end_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              tx_done_o,
    output logic              rx_done_o
);
    logic [DATA_W-1:0] tx_sr_q;
    logic [DATA_W-1:0] rx_sr_q;

    // Output is driven only while transmitting; otherwise the line idles high.
    assign sdo_o = (run_i && (dir_i == DIR_TX)) ? tx_sr_q[0] : 1'b1;

    // Transmit register: load on accept, move to the next bit at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sr_q <= '1;
        else if (accept_i)
            tx_sr_q <= tx_byte_i;
        else if (bit_end_i)
            tx_sr_q <= {1'b1, tx_sr_q[DATA_W-1:1]};
    end

    // Receive register: take sdi at the shift clock rising edge, LSB arrives first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sr_q <= '0;
        else if (sample_en_i && (dir_i == DIR_RX))
            rx_sr_q <= {sdi_i, rx_sr_q[DATA_W-1:1]};
    end

    // Received byte and completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte_o <= '0;
            tx_done_o <= 1'b0;
            rx_done_o <= 1'b0;
        end else if (accept_i) begin
            tx_done_o <= 1'b0;
            rx_done_o <= 1'b0;
        end else if (xfer_end_i) begin
            if (dir_i == DIR_RX) begin
                rx_byte_o <= rx_sr_q;
                rx_done_o <= 1'b1;
            end else begin
                tx_done_o <= 1'b1;
            end
        end
    end

    AST_SDO_STEADY_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_i) && run_i && !$past(bit_end_i)) |-> $stable(sdo_o));  // R4
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done_o && rx_done_o));  // R7
    AST_RXBYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_end_i && (dir_i == DIR_RX)) |=> $stable(rx_byte_o));  // R6
endmodule

// File: rtl/sync_shift_port.sv
// Top of the synchronous byte shifter. Connects the machine-cycle timer, the
// transfer sequencer and the shift datapath. One byte per request, half duplex.
// Assumes clk is the oscillator clock and the requests are synchronous to it.
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CYC_LEN  = 12,
    parameter int SCK_FALL = 4,
    parameter int SCK_RISE = 10,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rx_start,
    input  logic              sdi,
    output logic              sck,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_byte,
    output logic              tx_done,
    output logic              rx_done
);
    logic [PH_W-1:0] ph;
    logic            ph_last;
    logic            accept;
    ssp_dir_t        dir;
    logic            run;
    logic            bit_end;
    logic            sample_en;
    logic            xfer_end;

    ssp_cycle_timer #(.CYC_LEN(CYC_LEN)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph_o      (ph),
        .ph_last_o (ph_last)
    );

    ssp_seq_ctrl #(
        .CYC_LEN  (CYC_LEN),
        .NBITS    (DATA_W),
        .SCK_FALL (SCK_FALL),
        .SCK_RISE (SCK_RISE)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ph_i        (ph),
        .ph_last_i   (ph_last),
        .tx_load_i   (tx_load),
        .rx_start_i  (rx_start),
        .accept_o    (accept),
        .dir_o       (dir),
        .run_o       (run),
        .bit_end_o   (bit_end),
        .sample_en_o (sample_en),
        .xfer_end_o  (xfer_end),
        .sck_o       (sck)
    );

    ssp_shift_dp #(.DATA_W(DATA_W)) dp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .tx_byte_i   (tx_byte),
        .dir_i       (dir),
        .run_i       (run),
        .bit_end_i   (bit_end),
        .sample_en_i (sample_en),
        .xfer_end_i  (xfer_end),
        .sdi_i       (sdi),
        .sdo_o       (sdo),
        .rx_byte_o   (rx_byte),
        .tx_done_o   (tx_done),
        .rx_done_o   (rx_done)
    );
endmodule

// File: tb/sync_shift_port_tb_top.sv
`timescale 1ns/1ps
module sync_shift_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_load, rx_start, sdi;
    logic [7:0] tx_byte;
    logic       sck, sdo, tx_done, rx_done;
    logic [7:0] rx_byte;

    int   checks = 0;
    int   errors = 0;
    int   cyc;
    bit   finished = 0;
    logic [7:0] exp_rx;

    always #4 clk = ~clk;

    // Bench edge count since reset release (edge 1 is first with rst_n high).
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    sync_shift_port dut_i (
        .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_byte(tx_byte),
        .rx_start(rx_start), .sdi(sdi), .sck(sck), .sdo(sdo),
        .rx_byte(rx_byte), .tx_done(tx_done), .rx_done(rx_done)
    );

    // Vector: {is_rx, both, poke, data}
    localparam logic [10:0] VEC [0:8] = '{
        {1'b0, 1'b0, 1'b0, 8'h01},
        {1'b0, 1'b0, 1'b0, 8'h80},
        {1'b1, 1'b0, 1'b0, 8'hA5},
        {1'b1, 1'b0, 1'b0, 8'h01},
        {1'b0, 1'b0, 1'b1, 8'hA5},
        {1'b1, 1'b0, 1'b1, 8'h80},
        {1'b0, 1'b1, 1'b0, 8'h3C},
        {1'b1, 1'b0, 1'b0, 8'hFF},
        {1'b0, 1'b0, 1'b0, 8'h00}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic do_xfer(input bit is_rx, input bit both, input bit poke, input logic [7:0] val);
        int n, m, e, q, b;
        bit tx_mode;
        logic [7:0] prev_rx;
        @(negedge clk);
        n = cyc + 1;
        m = ((n / 12) + 1) * 12;
        tx_byte  = val;
        tx_load  = !is_rx || both;
        rx_start = is_rx || both;
        tx_mode  = !is_rx || both;
        prev_rx  = exp_rx;
        @(negedge clk);
        while (cyc <= m + 96) begin
            e = cyc;
            tx_load  = 1'b0;
            rx_start = 1'b0;
            if (e < m) begin
                check("R2 R4", "sck before boundary", sck, 1'b1);
                check("R2", "sdo before boundary", sdo, 1'b1);
                check("R7", "done flags cleared on accept", {tx_done, rx_done}, 2'b00);
            end else if (e < m + 96) begin
                q = (e - m) % 12;
                b = (e - m) / 12;
                check("R2 R4", "sck phase", sck, !(q >= 4 && q <= 9));
                if (tx_mode) check("R3", "sdo bit", sdo, val[b]);
                else         check("R10", "sdo idle in receive", sdo, 1'b1);
                if (!tx_mode) sdi = (q == 9) ? val[b] : ~val[b];
                if (poke && e == m + 30) begin
                    tx_byte  = ~val;
                    tx_load  = 1'b1;
                    rx_start = 1'b1;
                end
                if (e == m + 95) begin
                    check("R6", "rx_byte held before end", rx_byte, prev_rx);
                    check("R7", "done low before end", {tx_done, rx_done}, 2'b00);
                end
            end else begin
                if (both) check("R9", "tie gives transmit", {tx_done, rx_done}, 2'b10);
                else      check("R7", "done flag", {tx_done, rx_done}, tx_mode ? 2'b10 : 2'b01);
                if (tx_mode) check(both ? "R9" : "R6", "rx_byte kept", rx_byte, prev_rx);
                else         check("R5", "received byte", rx_byte, val);
            end
            @(negedge clk);
        end
        if (!tx_mode) exp_rx = val;
        sdi = 1'b0;
        if (poke) begin
            repeat (24) begin
                check("R8", "no extra transfer sck", sck, 1'b1);
                check("R8", "done kept", {tx_done, rx_done}, tx_mode ? 2'b10 : 2'b01);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; tx_load = 1'b0; rx_start = 1'b0; sdi = 1'b0; tx_byte = 8'h00;
        exp_rx = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset outputs", {sck, sdo, rx_byte, tx_done, rx_done}, {1'b1, 1'b1, 8'h00, 1'b0, 1'b0});
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++) begin
            repeat (i * 5) @(negedge clk);
            do_xfer(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
        end

        // Request captured exactly on a boundary edge: waits a full cycle (R2).
        while (((cyc + 2) % 12) != 0) @(negedge clk);
        do_xfer(1'b0, 1'b0, 1'b0, 8'h6D);
        // Request captured one edge before a boundary (R2).
        while (((cyc + 2) % 12) != 11) @(negedge clk);
        do_xfer(1'b1, 1'b0, 1'b0, 8'hC3);

        // Reset in the middle of a transmit (R1).
        @(negedge clk);
        tx_byte = 8'h0F; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid-transfer reset", {sck, sdo, rx_byte, tx_done, rx_done}, {1'b1, 1'b1, 8'h00, 1'b0, 1'b0});
        rst_n = 1'b1;
        exp_rx = 8'h00;
        repeat (13) begin
            check("R1", "idle after reset", {sck, sdo}, 2'b11);
            @(negedge clk);
        end
        do_xfer(1'b1, 1'b0, 1'b0, 8'h5A);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule